// File: doc/BRIEF.md
# SEC-DED 16-bit Error Detection and Correction Core

This block protects 16-bit memory words with a 6-bit check word. The code is a modified Hamming code. Every data bit maps to a distinct group of three check bits, and each check bit is the parity of eight data bits. On a write, the core computes the check word from the outgoing data and drives it out. On a read, the 22-bit word from memory (16 data plus 6 check bits) is captured and checked. The core then raises a single-error flag, a double-error flag, or neither. On request it drives out the corrected data together with the 6-bit syndrome, which shows the position of a failing bit.

A 2-bit mode input selects the function:

| Mode | Function |
|---|---|
| `00` | Encode |
| `01` | Read setup, both ports are inputs |
| `11` | Capture and flag |
| `10` | Correct, drive corrected data and syndrome |

Capture happens on the clock edge where `mode[1]` first rises to 1 into mode `11`. All outputs are registered and follow the mode one clock later. The bidirectional pins of a discrete part are replaced here by separate input and output buses, each output bus with its own enable.

Two of the check bits are stored with inverted sense. Because of this, a word of all zeros or all ones never passes as clean.

Top module: `secded16_edac`

## Requirements
- R1: One clock after `mode` is `00`, `chkOut` holds the check word of `dataIn`, `chkOe` is 1, `dataOe` is 0, and both flags are 0.
- R2: Check bit k is the XOR of the data bits listed below, and bits 0 and 1 are then inverted. Each data bit therefore lands in exactly three check bits.
  - bit0: d0,1,2,4,5,7,10,13
  - bit1: d0,1,3,6,8,9,11,12
  - bit2: d2,3,4,5,6,8,14,15
  - bit3: d2,3,7,9,10,11,14,15
  - bit4: d0,4,6,7,9,12,13,14
  - bit5: d1,5,8,10,11,12,13,15
- R3: `dataIn` and `chkIn` are captured only on the clock edge where `mode` is `11` and `mode[1]` was 0 on the previous edge. Changes to the inputs while `mode` stays at `11` have no effect on the later flags or corrected data.
- R4: One clock after `mode` is `01` or `11`, `dataOe` and `chkOe` are both 0. One clock after `mode` is `01`, both flags are 0.
- R5: The syndrome is the captured check word XOR the check word recomputed from the captured data. With a zero syndrome, both flags are 0 and correction returns the captured data with a zero syndrome.
- R6: A single flipped data bit sets `singleErr`=1 and `doubleErr`=0. In mode `10` that bit is inverted back, and `chkOut` shows the syndrome, which has weight 3.
- R7: A single flipped check bit sets `singleErr`=1 and `doubleErr`=0. The data passes unchanged, and the syndrome has weight 1.
- R8: Any two flipped bits among the 22 set both flags. The data is passed through uncorrected, and the syndrome is nonzero with even weight.
- R9: A captured word of all zeros and a captured word of all ones (data and check) are both reported as double errors.
- R10: After reset, `dataOut`, `chkOut`, `dataOe`, `chkOe`, `singleErr` and `doubleErr` are all 0.
- R11: One clock after `mode` is `10`, `dataOe` and `chkOe` are 1, and the flags still report the captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Function select: 00 encode, 01 read setup, 11 capture/flag, 10 correct |
| dataIn | input | 16 | Data from the write path or from memory |
| chkIn | input | 6 | Check word from memory |
| dataOut | output | 16 | Corrected data (mode 10) |
| dataOe | output | 1 | Enable for dataOut |
| chkOut | output | 6 | Generated check word (mode 00) or syndrome (mode 10) |
| chkOe | output | 1 | Enable for chkOut |
| singleErr | output | 1 | Error present in captured word |
| doubleErr | output | 1 | Uncorrectable (two-bit) error in captured word |

## Verification
The block's own encoder only produces consistent words, so faulty 22-bit words do not arise from its ports. The stimulus builds them: the bench computes a clean check word with its own encoder, then flips one data bit, one check bit, or two distinct bits of the 22 before presenting the word in mode `01`. Every single-bit position is swept directly, and random double flips and the all-zero and all-one words are mixed in. A further hard case is proving that the capture happens only once. After each capture, the inputs are replaced by their complement while the mode stays at `11`, so that any recapture would show up in the flags and in the corrected data.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 16;
  localparam int CHK_W  = 6;
  // check bits kept with inverted sense so all-0 / all-1 words fail
  localparam logic [CHK_W-1:0] INV_MASK = 6'b000011;

  typedef enum logic [1:0] {
    MODE_ENC  = 2'b00,
    MODE_LOAD = 2'b01,
    MODE_CORR = 2'b10,
    MODE_FLAG = 2'b11
  } mode_e;

  typedef struct packed {
    logic capture;
    logic encDrive;
    logic corrDrive;
    logic flagEn;
  } strobe_t;

  // column of the parity matrix for one data bit: distinct weight-3 codes
  function automatic logic [CHK_W-1:0] colMask(input int idx);
    logic [CHK_W-1:0] m;
    case (idx)
      0:  m = 6'h13;
      1:  m = 6'h23;
      2:  m = 6'h0D;
      3:  m = 6'h0E;
      4:  m = 6'h15;
      5:  m = 6'h25;
      6:  m = 6'h16;
      7:  m = 6'h19;
      8:  m = 6'h26;
      9:  m = 6'h1A;
      10: m = 6'h29;
      11: m = 6'h2A;
      12: m = 6'h32;
      13: m = 6'h31;
      14: m = 6'h1C;
      15: m = 6'h2C;
      default: m = '0;
    endcase
    return m;
  endfunction

  // row of the parity matrix, derived from the columns
  function automatic logic [DATA_W-1:0] rowMask(input int row);
    logic [DATA_W-1:0] r;
    logic [CHK_W-1:0]  c;
    r = '0;
    for (int i = 0; i < DATA_W; i++) begin
      c = colMask(i);
      r[i] = c[row];
    end
    return r;
  endfunction
endpackage

// File: rtl/edac_codec.sv
module edac_codec
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  check
);
  logic [CHK_W-1:0] rawParity;

  for (genvar r = 0; r < CHK_W; r++) begin : g_row
    localparam logic [DATA_W-1:0] ROW_M = rowMask(r);
    assign rawParity[r] = ^(data & ROW_M);
  end

  assign check = rawParity ^ INV_MASK;
endmodule

// File: rtl/edac_ctrl.sv
module edac_ctrl
  import secded_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  output strobe_t    strb
);
  logic s1Prev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) s1Prev <= 1'b0;
    else       s1Prev <= mode[1];
  end

  always_comb begin
    strb.capture   = (mode == MODE_FLAG) && !s1Prev;
    strb.encDrive  = (mode == MODE_ENC);
    strb.corrDrive = (mode == MODE_CORR);
    strb.flagEn    = mode[1];
  end
endmodule

// File: rtl/edac_datapath.sv
module edac_datapath
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CHK_W-1:0]  chkIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [CHK_W-1:0]  chkOut,
  output logic              chkOe,
  output logic              singleErr,
  output logic              doubleErr
);
  logic [DATA_W-1:0] capData;
  logic [CHK_W-1:0]  capChk;
  logic [CHK_W-1:0]  liveChk;
  logic [CHK_W-1:0]  capRecalc;
  logic [CHK_W-1:0]  syn;
  logic              synOdd, anyErr, isSingle, isDouble;
  logic [DATA_W-1:0] flipVec;
  logic [DATA_W-1:0] corrData;

  edac_codec encLive (.data(dataIn),  .check(liveChk));
  edac_codec encCap  (.data(capData), .check(capRecalc));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capData <= '0;
      capChk  <= '0;
    end else if (strb.capture) begin
      capData <= dataIn;
      capChk  <= chkIn;
    end
  end

  assign syn      = capChk ^ capRecalc;
  assign synOdd   = ^syn;
  assign anyErr   = |syn;
  assign isSingle = anyErr && synOdd;
  assign isDouble = anyErr && !synOdd;

  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam logic [CHK_W-1:0] COL = colMask(i);
    assign flipVec[i] = isSingle && (syn == COL);
  end

  assign corrData = capData ^ flipVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= '0;
      dataOe    <= 1'b0;
      chkOut    <= '0;
      chkOe     <= 1'b0;
      singleErr <= 1'b0;
      doubleErr <= 1'b0;
    end else begin
      dataOe    <= strb.corrDrive;
      chkOe     <= strb.encDrive || strb.corrDrive;
      dataOut   <= strb.corrDrive ? corrData : '0;
      if (strb.encDrive)       chkOut <= liveChk;
      else if (strb.corrDrive) chkOut <= syn;
      else                     chkOut <= '0;
      singleErr <= strb.flagEn && anyErr;
      doubleErr <= strb.flagEn && isDouble;
    end
  end
endmodule

// File: rtl/secded16_edac.sv
module secded16_edac
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CHK_W-1:0]  chkIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [CHK_W-1:0]  chkOut,
  output logic              chkOe,
  output logic              singleErr,
  output logic              doubleErr
);
  strobe_t strb;

  edac_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .mode(mode), .strb(strb)
  );

  edac_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .dataIn(dataIn), .chkIn(chkIn),
    .dataOut(dataOut), .dataOe(dataOe),
    .chkOut(chkOut), .chkOe(chkOe),
    .singleErr(singleErr), .doubleErr(doubleErr)
  );
endmodule

// File: rtl/secded16_edac_chk.sv
module secded16_edac_chk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  mode,
  input logic        dataOe,
  input logic [5:0]  chkOut,
  input logic        chkOe,
  input logic        singleErr,
  input logic        doubleErr
);
  // R4
  oe_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01 || mode == 2'b11) |=> (!dataOe && !chkOe));

  // R4
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01) |=> (!singleErr && !doubleErr));

  // R1
  enc_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00) |=> (chkOe && !dataOe && !singleErr && !doubleErr));

  // R11
  corr_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10) |=> (dataOe && chkOe));

  // R8
  dbl_has_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doubleErr |-> singleErr);

  // R5
  clean_syn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && !singleErr) |-> (chkOut == 6'd0));

  // R8
  dbl_even_syn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && doubleErr) |-> (chkOut != 6'd0 && !(^chkOut)));
endmodule

bind secded16_edac secded16_edac_chk chk_i (
  .clk(clk), .rstN(rstN), .mode(mode), .dataOe(dataOe),
  .chkOut(chkOut), .chkOe(chkOe),
  .singleErr(singleErr), .doubleErr(doubleErr)
);

// File: tb/secded16_edac_tb_top.sv
module secded16_edac_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  mode;
  logic [15:0] dataIn;
  logic [5:0]  chkIn;
  logic [15:0] dataOut;
  logic        dataOe;
  logic [5:0]  chkOut;
  logic        chkOe;
  logic        singleErr;
  logic        doubleErr;

  int  nVec = 0;
  int  nBad = 0;
  bit  done = 0;

  localparam logic [15:0] ROWS [6] = '{16'h24B7, 16'h1B4B, 16'hC17C,
                                       16'hCE8C, 16'h72D1, 16'hBD22};

  always #5 clk = ~clk;

  secded16_edac dut_i (
    .clk(clk), .rstN(rstN), .mode(mode), .dataIn(dataIn), .chkIn(chkIn),
    .dataOut(dataOut), .dataOe(dataOe), .chkOut(chkOut), .chkOe(chkOe),
    .singleErr(singleErr), .doubleErr(doubleErr)
  );

  function automatic logic [5:0] benchEnc(input logic [15:0] d);
    logic [5:0] c;
    for (int r = 0; r < 6; r++) c[r] = ^(d & ROWS[r]);
    return c ^ 6'b000011;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doEncode(input logic [15:0] d);
    logic [5:0] e;
    @(negedge clk);
    mode = 2'b00; dataIn = d;
    @(negedge clk);
    e = benchEnc(d);
    check(chkOut == e, "R2", "check word", {26'd0, chkOut}, {26'd0, e});
    check(chkOe && !dataOe && !singleErr && !doubleErr, "R1", "enc oe/flags",
          {28'd0, chkOe, dataOe, singleErr, doubleErr}, 32'h8);
  endtask

  // present a 22-bit word, capture, verify flags then correction
  task automatic doRead(input logic [15:0] d, input logic [5:0] c,
                        input logic expS, input logic expD,
                        input logic [15:0] expData, input string req);
    logic [5:0] expSyn;
    expSyn = c ^ benchEnc(d);
    @(negedge clk);
    mode = 2'b01; dataIn = d; chkIn = c;
    @(negedge clk);
    check(!dataOe && !chkOe && !singleErr && !doubleErr, "R4", "load state",
          {28'd0, dataOe, chkOe, singleErr, doubleErr}, 32'h0);
    mode = 2'b11;
    @(negedge clk);
    // R3: inputs change while staying in 11 must be ignored
    dataIn = ~d; chkIn = ~c;
    @(negedge clk);
    check(singleErr == expS && doubleErr == expD, req, "flags",
          {30'd0, singleErr, doubleErr}, {30'd0, expS, expD});
    check(!dataOe && !chkOe, "R4", "oe in flag mode",
          {30'd0, dataOe, chkOe}, 32'h0);
    mode = 2'b10;
    @(negedge clk);
    check(dataOut == expData, req, "corrected data (R3 hold)",
          {16'd0, dataOut}, {16'd0, expData});
    check(chkOut == expSyn, req, "syndrome", {26'd0, chkOut}, {26'd0, expSyn});
    check(dataOe && chkOe && singleErr == expS && doubleErr == expD, "R11",
          "correct-mode oe/flags",
          {28'd0, dataOe, chkOe, singleErr, doubleErr},
          {28'd0, 1'b1, 1'b1, expS, expD});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0] g, d;
    logic [5:0]  c;
    int          kind, p, q, seed;
    seed = $urandom(32'h5EC0DED);
    rstN = 1'b0; mode = 2'b01; dataIn = '0; chkIn = '0;
    repeat (3) @(negedge clk);
    // R10
    check(dataOut == 0 && chkOut == 0 && !dataOe && !chkOe && !singleErr && !doubleErr,
          "R10", "reset state", {dataOut, 4'd0, chkOut, dataOe, chkOe},
          32'h0);
    rstN = 1'b1;

    // directed encodes
    doEncode(16'h0000);
    doEncode(16'hFFFF);
    doEncode(16'h0001);
    doEncode(16'h8000);
    doEncode(16'hA5C3);

    // R9 gross errors
    doRead(16'h0000, 6'h00, 1'b1, 1'b1, 16'h0000, "R9");
    doRead(16'hFFFF, 6'h3F, 1'b1, 1'b1, 16'hFFFF, "R9");

    // R5 clean word
    doRead(16'h1234, benchEnc(16'h1234), 1'b0, 1'b0, 16'h1234, "R5");

    // R6 every data bit
    for (int i = 0; i < 16; i++) begin
      g = 16'h3C5A ^ (16'h1 << i);
      doRead(g ^ (16'h1 << ((i + 5) % 16)), benchEnc(g), 1'b1, 1'b0, g, "R6");
    end
    // R7 every check bit
    for (int i = 0; i < 6; i++) begin
      g = 16'hC0DE;
      doRead(g, benchEnc(g) ^ (6'h1 << i), 1'b1, 1'b0, g, "R7");
    end

    // random mix
    for (int n = 0; n < 300; n++) begin
      g = 16'($urandom);
      doEncode(g);
      d = g; c = benchEnc(g);
      kind = $urandom_range(0, 3);
      if (kind == 0) begin
        doRead(d, c, 1'b0, 1'b0, g, "R5");
      end else if (kind == 1) begin
        d[$urandom_range(0, 15)] ^= 1'b1;
        doRead(d, c, 1'b1, 1'b0, g, "R6");
      end else if (kind == 2) begin
        c[$urandom_range(0, 5)] ^= 1'b1;
        doRead(d, c, 1'b1, 1'b0, g, "R7");
      end else begin
        p = $urandom_range(0, 21);
        q = $urandom_range(0, 20);
        if (q >= p) q++;
        if (p < 16) d[p] ^= 1'b1; else c[p-16] ^= 1'b1;
        if (q < 16) d[q] ^= 1'b1; else c[q-16] ^= 1'b1;
        doRead(d, c, 1'b1, 1'b1, d, "R8");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule